// File: doc/BRIEF.md
# Flash Control Register Protection Unit

This block sits in front of a flash array and holds three byte-wide control registers on a simple synchronous register bus. The first is a lock register that can be set only once per reset in normal operation. The second is a configuration register whose single bit decides whether the boot block may be programmed or erased. The third is a test register that only special mode can see or change.

A request port takes a target flash address. It answers in the same cycle whether a program or erase at that address is allowed. Two static inputs place the boot block either in the low or the high half of the address space, and choose between a 1 KB and a 2 KB block. An external program-enable status input freezes the boot-protect bit while a program or erase operation is running.

Top module: `flash_guard`

## Requirements
- R1: The lock register sits at offset 0xF4 and uses bit 0 only. It resets to 0, and bits 7..1 always read 0.
- R2: In normal mode (special_mode=0), the first write to 0xF4 after reset loads wdata[0] into the lock bit. Every later normal-mode write to 0xF4 is ignored until the next reset.
- R3: The configuration register sits at offset 0xF5 and holds the boot-protect bit in bit 0. The bit resets to 1, and bits 7..1 read 0.
- R4: A write to 0xF5 updates boot-protect from wdata[0] only while the lock bit is 0. While the lock bit is 1, the write is ignored.
- R5: A write to 0xF5 is ignored while prog_en_active is 1.
- R6: req_allow is 1 when req_valid is 1 and either req_addr lies outside the boot block or boot-protect is 0. Otherwise req_allow is 0. The answer is combinational and appears in the same cycle as the request.
- R7: With map_high=1, the boot block is 0xF800–0xFFFF, or 0xFC00–0xFFFF when blk_small=1. With map_high=0, it is 0x7800–0x7FFF, or 0x7C00–0x7FFF when blk_small=1.
- R8: The test register sits at offset 0xF6. In normal mode, writes to it are ignored and it reads as 0.
- R9: In special mode (special_mode=1), the lock bit may be written any number of times. The test register also stores and returns all 8 bits, and resets to 0.
- R10: Reads of any offset other than 0xF4, 0xF5 and 0xF6 return 0. Writes to those offsets change no register.
- R11: reg_rdata is registered. It shows the register addressed by reg_addr at a clock edge from that edge onward, and it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| special_mode | input | 1 | 1 = special/test mode, 0 = normal mode |
| prog_en_active | input | 1 | External program/erase-enable status |
| map_high | input | 1 | Boot block in upper half of the address space |
| blk_small | input | 1 | 1 = 1 KB boot block, 0 = 2 KB |
| reg_addr | input | 8 | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| req_valid | input | 1 | Program/erase request present |
| req_addr | input | 16 | Flash address of the request |
| req_allow | output | 1 | Request may proceed |

## Verification
The bench goes after the second normal-mode write to the lock register. A design that rewrites the lock bit there would let software reopen the boot block after locking it. It also checks that a reset re-arms the single allowed lock write, and that special mode may rewrite the lock bit freely.

It probes the boot-block edges one address inside and one address outside, for all four map and size choices. An off-by-one range compare would wrongly deny or allow those addresses. Finally, it confirms that boot-protect freezes under either the lock bit or program-enable, that the test register stays zero in normal mode, and that unmapped offsets neither read back data nor disturb the real registers.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LOCK = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_TEST = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/fg_lock_reg.sv
module fg_lock_reg (
  input  logic clk,
  input  logic rst,
  input  logic special_mode,
  input  logic wr_en,
  input  logic wr_bit,
  output logic lock_q
);
  logic used_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      used_q <= 1'b0;
    end else if (wr_en) begin
      if (special_mode) begin
        lock_q <= wr_bit;
      end else if (!used_q) begin
        lock_q <= wr_bit;
        used_q <= 1'b1;
      end
    end
  end

  // R2: once the single normal-mode write is spent, normal writes leave lock alone
  a_r2_lock_once: assert property (@(posedge clk) disable iff (rst)
    (used_q && !special_mode) |=> $stable(lock_q));
endmodule

// File: rtl/fg_cfg_reg.sv
module fg_cfg_reg (
  input  logic clk,
  input  logic rst,
  input  logic lock,
  input  logic prog_en,
  input  logic wr_en,
  input  logic wr_bit,
  output logic bootp_q
);
  always_ff @(posedge clk) begin
    if (rst)
      bootp_q <= 1'b1;
    else if (wr_en && !lock && !prog_en)
      bootp_q <= wr_bit;
  end

  a_r4_frozen_by_lock: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable(bootp_q));
  a_r5_frozen_by_prog: assert property (@(posedge clk) disable iff (rst)
    prog_en |=> $stable(bootp_q));
endmodule

// File: rtl/fg_test_reg.sv
module fg_test_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              special_mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] test_q
);
  always_ff @(posedge clk) begin
    if (rst)
      test_q <= '0;
    else if (wr_en && special_mode)
      test_q <= wr_data;
  end

  // R8: normal mode never alters the test bits
  a_r8_normal_inert: assert property (@(posedge clk) disable iff (rst)
    !special_mode |=> $stable(test_q));
endmodule

// File: rtl/fg_boot_window.sv
module fg_boot_window #(
  parameter int ADDR_W     = 16,
  parameter int SMALL_BITS = 10,
  parameter int LARGE_BITS = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              map_high,
  input  logic              blk_small,
  output logic              in_boot
);
  localparam int LOW_W = ADDR_W - 1;
  localparam logic [LOW_W-1:0] MASK_SMALL = LOW_W'((64'd1 << SMALL_BITS) - 64'd1);
  localparam logic [LOW_W-1:0] MASK_LARGE = LOW_W'((64'd1 << LARGE_BITS) - 64'd1);

  logic [LOW_W-1:0] offset_mask;

  always_comb begin
    offset_mask = blk_small ? MASK_SMALL : MASK_LARGE;
    in_boot = (addr[ADDR_W-1] == map_high) && (&(addr[LOW_W-1:0] | offset_mask));
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          OFS_W      = 8,
  parameter int          ADDR_W     = 16,
  parameter int          SMALL_BITS = 10,
  parameter int          LARGE_BITS = 11,
  parameter logic [7:0]  LOCK_OFS   = 8'hF4,
  parameter logic [7:0]  CFG_OFS    = 8'hF5,
  parameter logic [7:0]  TEST_OFS   = 8'hF6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              special_mode,
  input  logic              prog_en_active,
  input  logic              map_high,
  input  logic              blk_small,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_allow
);
  reg_sel_e          sel;
  logic              lock_q;
  logic              bootp_q;
  logic [DATA_W-1:0] test_q;
  logic              in_boot;

  always_comb begin
    if (reg_addr == OFS_W'(LOCK_OFS))      sel = SEL_LOCK;
    else if (reg_addr == OFS_W'(CFG_OFS))  sel = SEL_CFG;
    else if (reg_addr == OFS_W'(TEST_OFS)) sel = SEL_TEST;
    else                                   sel = SEL_NONE;
  end

  fg_lock_reg u_lock (
    .clk(clk), .rst(rst), .special_mode(special_mode),
    .wr_en(reg_we && sel == SEL_LOCK), .wr_bit(reg_wdata[0]), .lock_q(lock_q)
  );

  fg_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .lock(lock_q), .prog_en(prog_en_active),
    .wr_en(reg_we && sel == SEL_CFG), .wr_bit(reg_wdata[0]), .bootp_q(bootp_q)
  );

  fg_test_reg #(.DATA_W(DATA_W)) u_test (
    .clk(clk), .rst(rst), .special_mode(special_mode),
    .wr_en(reg_we && sel == SEL_TEST), .wr_data(reg_wdata), .test_q(test_q)
  );

  fg_boot_window #(.ADDR_W(ADDR_W), .SMALL_BITS(SMALL_BITS), .LARGE_BITS(LARGE_BITS)) u_win (
    .addr(req_addr), .map_high(map_high), .blk_small(blk_small), .in_boot(in_boot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (sel)
        SEL_LOCK: reg_rdata <= {{(DATA_W-1){1'b0}}, lock_q};
        SEL_CFG:  reg_rdata <= {{(DATA_W-1){1'b0}}, bootp_q};
        SEL_TEST: reg_rdata <= special_mode ? test_q : '0;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  assign req_allow = req_valid && (!in_boot || !bootp_q);

  // R6: a protected boot-block request is never allowed
  a_r6_deny_boot: assert property (@(posedge clk) disable iff (rst)
    (req_valid && in_boot && bootp_q) |-> !req_allow);
  // R6: no grant without a request
  a_r6_no_idle_grant: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> !req_allow);
  // R10: an unmapped read returns zero one edge later
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_NONE) |=> (reg_rdata == '0));
endmodule

// File: tb/sim_flash_guard.sv
`timescale 1ns/1ps
module sim_flash_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        special_mode = 1'b0;
  logic        prog_en_active = 1'b0;
  logic        map_high = 1'b0;
  logic        blk_small = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = 16'h0000;
  logic        req_allow;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flash_guard u0 (
    .clk(clk), .rst(rst), .special_mode(special_mode), .prog_en_active(prog_en_active),
    .map_high(map_high), .blk_small(blk_small), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_allow(req_allow)
  );

  // vector: {is_write, special, offset, data(wdata or expected read), tag}
  localparam int NV = 25;
  localparam logic [21:0] VEC [0:NV-1] = '{
    {1'b0, 1'b0, 8'hF4, 8'h00, 4'd1},  // R1 reset
    {1'b0, 1'b0, 8'hF5, 8'h01, 4'd3},  // R3 reset
    {1'b0, 1'b0, 8'hF6, 8'h00, 4'd8},  // R8
    {1'b1, 1'b0, 8'hF5, 8'hFE, 4'd4},
    {1'b0, 1'b0, 8'hF5, 8'h00, 4'd4},  // R4 unlocked write
    {1'b1, 1'b0, 8'hF5, 8'h01, 4'd4},
    {1'b0, 1'b0, 8'hF5, 8'h01, 4'd3},  // R3 upper bits zero
    {1'b1, 1'b0, 8'hF6, 8'hFF, 4'd8},
    {1'b0, 1'b0, 8'hF6, 8'h00, 4'd8},  // R8 normal write ignored
    {1'b1, 1'b0, 8'hF4, 8'hFF, 4'd2},
    {1'b0, 1'b0, 8'hF4, 8'h01, 4'd1},  // R1 only bit 0
    {1'b1, 1'b0, 8'hF4, 8'h00, 4'd2},
    {1'b0, 1'b0, 8'hF4, 8'h01, 4'd2},  // R2 second write ignored
    {1'b1, 1'b0, 8'hF5, 8'h00, 4'd4},
    {1'b0, 1'b0, 8'hF5, 8'h01, 4'd4},  // R4 locked write ignored
    {1'b0, 1'b0, 8'hF7, 8'h00, 4'd10}, // R10
    {1'b1, 1'b1, 8'hF4, 8'h00, 4'd9},
    {1'b0, 1'b1, 8'hF4, 8'h00, 4'd9},  // R9 special rewrite
    {1'b1, 1'b1, 8'hF4, 8'h01, 4'd9},
    {1'b0, 1'b1, 8'hF4, 8'h01, 4'd9},  // R9
    {1'b1, 1'b1, 8'hF4, 8'h00, 4'd9},
    {1'b0, 1'b1, 8'hF4, 8'h00, 4'd9},  // R9
    {1'b1, 1'b1, 8'hF6, 8'hA5, 4'd9},
    {1'b0, 1'b1, 8'hF6, 8'hA5, 4'd9},  // R9 test register
    {1'b0, 1'b0, 8'hF6, 8'h00, 4'd8}   // R8 hidden in normal mode
  };

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] ofs, input logic [7:0] d);
    @(negedge clk);
    reg_addr = ofs; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic do_read(input string tag, input logic [7:0] ofs, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = ofs; reg_we = 1'b0;
    @(negedge clk);
    check8(tag, reg_rdata, exp);
  endtask

  task automatic do_req(input string tag, input logic hi, input logic sm,
                        input logic v, input logic [15:0] a, input logic exp);
    @(negedge clk);
    map_high = hi; blk_small = sm; req_valid = v; req_addr = a;
    #1;
    check8(tag, {7'b0, req_allow}, {7'b0, exp});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; special_mode = 1'b0; prog_en_active = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check8("R11 rdata after reset", reg_rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      string t;
      v = VEC[i];
      t = $sformatf("R%0d vec%0d", v[3:0], i);
      @(negedge clk);
      special_mode = v[20];
      if (v[21]) do_write(v[19:12], v[11:4]);
      else       do_read(t, v[19:12], v[11:4]);
    end

    // R9: test register returns to zero on reset
    do_reset();
    special_mode = 1'b1;
    do_read("R9 test reset", 8'hF6, 8'h00);
    special_mode = 1'b0;

    // R6/R7 boot window, boot-protect = 1
    do_req("R7 lo2k below",  1'b0, 1'b0, 1'b1, 16'h77FF, 1'b1);
    do_req("R7 lo2k first",  1'b0, 1'b0, 1'b1, 16'h7800, 1'b0);
    do_req("R7 lo2k last",   1'b0, 1'b0, 1'b1, 16'h7FFF, 1'b0);
    do_req("R7 lo2k upper",  1'b0, 1'b0, 1'b1, 16'hFFFF, 1'b1);
    do_req("R7 lo1k below",  1'b0, 1'b1, 1'b1, 16'h7BFF, 1'b1);
    do_req("R7 lo1k first",  1'b0, 1'b1, 1'b1, 16'h7C00, 1'b0);
    do_req("R7 hi2k below",  1'b1, 1'b0, 1'b1, 16'hF7FF, 1'b1);
    do_req("R7 hi2k first",  1'b1, 1'b0, 1'b1, 16'hF800, 1'b0);
    do_req("R7 hi2k lower",  1'b1, 1'b0, 1'b1, 16'h7FFF, 1'b1);
    do_req("R7 hi1k below",  1'b1, 1'b1, 1'b1, 16'hFBFF, 1'b1);
    do_req("R7 hi1k first",  1'b1, 1'b1, 1'b1, 16'hFC00, 1'b0);
    do_req("R6 no request",  1'b1, 1'b0, 1'b0, 16'h1000, 1'b0);

    // R5: program-enable freezes boot-protect
    prog_en_active = 1'b1;
    do_write(8'hF5, 8'h00);
    prog_en_active = 1'b0;
    do_read("R5 frozen by prog_en", 8'hF5, 8'h01);
    do_write(8'hF5, 8'h00);
    do_read("R4 write after prog_en", 8'hF5, 8'h00);
    do_req("R6 unprotected boot", 1'b1, 1'b0, 1'b1, 16'hF800, 1'b1);

    // R2: reset re-armed the single lock write
    do_write(8'hF4, 8'h01);
    do_read("R2 lock after reset", 8'hF4, 8'h01);
    do_write(8'hF5, 8'h01);
    do_read("R4 locked", 8'hF5, 8'h00);

    // R10: unmapped write disturbs nothing
    do_write(8'hF3, 8'hFF);
    do_write(8'hF7, 8'hFF);
    do_read("R10 lock intact", 8'hF4, 8'h01);
    do_read("R10 cfg intact", 8'hF5, 8'h00);
    do_read("R10 unmapped F3", 8'hF3, 8'h00);

    // R11: read data only moves at an edge
    @(negedge clk);
    reg_addr = 8'hF4;
    #1;
    check8("R11 holds before edge", reg_rdata, 8'h00);
    @(negedge clk);
    check8("R11 after edge", reg_rdata, 8'h01);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule